// File: doc/BRIEF.md
# Protection-Aware Checksum Accumulator

This block forms the 16-bit verification checksum of a nonvolatile program image while a reader streams the image past it one word at a time. Each streamed word arrives as an address and a data value. The block keeps two running sums side by side. The wide sum covers the full user range, and the narrow sum covers only the small block that stays readable under protection. Both sums drop any carry past bit 15.

When the done strobe arrives, the block reads the protection bit from the configuration word presented at that moment. It then picks the matching running sum and adds the configuration word masked to its low ten bits. When protection is on, it also adds a 16-bit value packed from the low nibbles of the four ID words. The result is registered and flagged valid for one cycle. A clear input restarts the accumulation for a new image.

Because both sums are kept, one pass over the image is enough to produce either checksum. Several done strobes may be issued on the same accumulation.

Top module: `prot_csum_acc`

## Requirements
- R1: While reset is asserted and directly after it, `sum_out` is 0 and `sum_vld` is 0.
- R2: All sums are taken modulo 2^16. A carry past bit 15 is dropped.
- R3: With protection off, the result is the sum of the words at addresses 0x000 to 0x3FE, plus `cfg_word & 0x3FF`.
- R4: With protection on, the result is the sum of the words at addresses 0x000 to 0x03F, plus `cfg_word & 0x3FF`, plus the packed ID value.
- R5: The packed ID value is {ID0[3:0], ID1[3:0], ID2[3:0], ID3[3:0]}. ID0 is `id_words[11:0]` and ID3 is `id_words[47:36]`, so IDs 1, 2, 3, 4 pack to 0x1234.
- R6: Protection is on when `cfg_word[4]` is 0. The bit is sampled in the cycle in which `done` is high, so one accumulation can be finished under either setting.
- R7: A streamed word whose address lies outside the range selected at done has no effect on the result. This covers 0x3FF and above in every case, and 0x040 to 0x3FE when protection is on.
- R8: Only bits [11:0] of `word_data` are added, zero-extended to 16 bits. Bits [13:12] have no effect.
- R9: `clr` zeroes the accumulation. A word presented in the same cycle as `clr` is dropped.
- R10: After `done` is seen at a clock edge, `sum_out` carries the result from the next edge on, and `sum_vld` is high for exactly that one cycle. Outside such an update, `sum_out` holds its value. A `done` does not clear the accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Restart the accumulation |
| word_vld | input | 1 | A streamed word is present |
| word_addr | input | 11 | Address of the streamed word |
| word_data | input | 14 | Data of the streamed word; the top two bits are ignored |
| cfg_word | input | 12 | Configuration word; bit 4 = 0 means protected |
| id_words | input | 48 | Four ID words, ID0 in bits [11:0] |
| done | input | 1 | Finish the checksum with the current configuration and IDs |
| sum_out | output | 16 | Registered checksum |
| sum_vld | output | 1 | One-cycle flag marking a new `sum_out` |

## Verification
The assertions check four things on every cycle:
- `sum_vld` follows `done` by exactly one cycle.
- `sum_out` holds between updates.
- `clr` empties both running sums.
- Out-of-range words leave the affected running sum untouched, and in-range words grow the narrow sum by their low twelve bits with wraparound.

Some behaviour only the bench scenarios can show. These cover the full checksum value under each protection setting, and the ID packing order, including the 0x1234 example. They also cover finishing the same stream twice under opposite settings, and a wrapping sum built from a long run of all-ones words.

// File: rtl/prot_csum_acc.sv
module prot_csum_acc #(
  parameter int ADDR_W      = 11,
  parameter int DIN_W       = 14,
  parameter int WORD_W      = 12,
  parameter int SUM_W       = 16,
  parameter int NUM_ID      = 4,
  parameter int WIDE_LAST   = 'h3FE,
  parameter int NARROW_LAST = 'h03F,
  parameter int CFG_MASK    = 'h3FF,
  parameter int PROT_BIT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     word_vld,
  input  logic [ADDR_W-1:0]        word_addr,
  input  logic [DIN_W-1:0]         word_data,
  input  logic [WORD_W-1:0]        cfg_word,
  input  logic [NUM_ID*WORD_W-1:0] id_words,
  input  logic                     done,
  output logic [SUM_W-1:0]         sum_out,
  output logic                     sum_vld
);
  localparam int NIB = SUM_W / NUM_ID;

  logic [SUM_W-1:0] acc_wide, acc_narrow, word_ext, cfg_term, id_pack, final_sum;
  logic in_wide, in_narrow, prot_on;

  assign word_ext  = SUM_W'(word_data[WORD_W-1:0]);
  assign in_wide   = word_addr <= ADDR_W'(WIDE_LAST);
  assign in_narrow = word_addr <= ADDR_W'(NARROW_LAST);
  assign cfg_term  = SUM_W'(cfg_word & WORD_W'(CFG_MASK));
  assign prot_on   = ~cfg_word[PROT_BIT];

  for (genvar g = 0; g < NUM_ID; g++) begin : g_pack
    assign id_pack[SUM_W-1-g*NIB -: NIB] = id_words[g*WORD_W +: NIB];
  end

  assign final_sum = (prot_on ? acc_narrow : acc_wide) + cfg_term
                   + (prot_on ? id_pack : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_wide   <= '0;
      acc_narrow <= '0;
    end else if (clr) begin
      acc_wide   <= '0;
      acc_narrow <= '0;
    end else if (word_vld) begin
      if (in_wide)   acc_wide   <= acc_wide + word_ext;
      if (in_narrow) acc_narrow <= acc_narrow + word_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= done;
      if (done) sum_out <= final_sum;
    end
  end
endmodule

// File: rtl/prot_csum_acc_chk.sv
module prot_csum_acc_chk #(
  parameter int ADDR_W      = 11,
  parameter int DIN_W       = 14,
  parameter int WORD_W      = 12,
  parameter int SUM_W       = 16,
  parameter int WIDE_LAST   = 'h3FE,
  parameter int NARROW_LAST = 'h03F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              word_vld,
  input logic [ADDR_W-1:0] word_addr,
  input logic [DIN_W-1:0]  word_data,
  input logic              done,
  input logic [SUM_W-1:0]  sum_out,
  input logic              sum_vld,
  input logic [SUM_W-1:0]  acc_wide,
  input logic [SUM_W-1:0]  acc_narrow
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (sum_out == '0 && !sum_vld));

  // R10
  vld_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> sum_vld);

  // R10
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |=> !sum_vld);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(sum_out));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_wide == '0 && acc_narrow == '0));

  // R7
  wide_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !clr && word_addr > ADDR_W'(WIDE_LAST)) |=> ($stable(acc_wide) && $stable(acc_narrow)));

  // R7
  narrow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !clr && word_addr > ADDR_W'(NARROW_LAST)) |=> $stable(acc_narrow));

  // R2 R8
  narrow_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !clr && word_addr <= ADDR_W'(NARROW_LAST)) |=>
      acc_narrow == SUM_W'($past(acc_narrow) + SUM_W'($past(word_data[WORD_W-1:0]))));
endmodule

bind prot_csum_acc prot_csum_acc_chk #(
  .ADDR_W(ADDR_W), .DIN_W(DIN_W), .WORD_W(WORD_W), .SUM_W(SUM_W),
  .WIDE_LAST(WIDE_LAST), .NARROW_LAST(NARROW_LAST)
) i_prot_csum_acc_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .word_vld(word_vld),
  .word_addr(word_addr), .word_data(word_data), .done(done),
  .sum_out(sum_out), .sum_vld(sum_vld),
  .acc_wide(acc_wide), .acc_narrow(acc_narrow)
);

// File: tb/test_prot_csum_acc.sv
module test_prot_csum_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        word_vld = 1'b0;
  logic [10:0] word_addr = '0;
  logic [13:0] word_data = '0;
  logic [11:0] cfg_word = 12'hFFF;
  logic [47:0] id_words = '0;
  logic        done = 1'b0;
  logic [15:0] sum_out;
  logic        sum_vld;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_wide = '0;
  logic [15:0] m_narrow = '0;

  always #2 clk = ~clk;

  prot_csum_acc i_prot_csum_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .word_vld(word_vld),
    .word_addr(word_addr), .word_data(word_data), .cfg_word(cfg_word),
    .id_words(id_words), .done(done), .sum_out(sum_out), .sum_vld(sum_vld)
  );

  function automatic logic [15:0] pack_ids(input logic [47:0] ids);
    return {ids[3:0], ids[15:12], ids[27:24], ids[39:36]};
  endfunction

  function automatic logic [15:0] expect_sum(input logic [11:0] cfg, input logic [47:0] ids,
                                             input logic [15:0] wide, input logic [15:0] narrow);
    logic [15:0] s;
    if (cfg[4]) s = wide + {4'h0, cfg & 12'h3FF};
    else        s = narrow + {4'h0, cfg & 12'h3FF} + pack_ids(ids);
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] a, input logic [13:0] d);
    @(negedge clk);
    word_vld = 1'b1; word_addr = a; word_data = d;
    if (a <= 11'h3FE) m_wide = m_wide + {4'h0, d[11:0]};
    if (a <= 11'h03F) m_narrow = m_narrow + {4'h0, d[11:0]};
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_wide = '0; m_narrow = '0;
  endtask

  task automatic finish_and_check(input string req);
    logic [15:0] e;
    e = expect_sum(cfg_word, id_words, m_wide, m_narrow);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check({req, " valid"}, 32'(sum_vld), 32'd1);
    check({req, " sum"}, 32'(sum_out), 32'(e));
    @(negedge clk);
    check({req, " valid drops (R10)"}, 32'(sum_vld), 32'd0);
    check({req, " sum holds (R10)"}, 32'(sum_out), 32'(e));
  endtask

  task automatic random_stream(input int n);
    for (int i = 0; i < n; i++) send(11'($urandom), 14'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5231));
    repeat (3) @(negedge clk);
    check("R1 reset sum", 32'(sum_out), 32'd0);
    check("R1 reset valid", 32'(sum_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset sum", 32'(sum_out), 32'd0);
    check("R1 after reset valid", 32'(sum_vld), 32'd0);

    // R5 example: IDs 1..4, empty stream, protected
    cfg_word = 12'hFEF; id_words = {12'h004, 12'h003, 12'h002, 12'h001};
    finish_and_check("R5 id example");
    check("R5 packed value", 32'(sum_out), 32'(16'h03EF + 16'h1234));

    // R3 unprotected random stream
    do_clear();
    cfg_word = 12'hA5F; id_words = 48'($urandom) << 16 | 48'($urandom);
    random_stream(300);
    finish_and_check("R3 unprotected");
    // R6 same stream, now protected, no clear in between
    cfg_word = 12'hA4F;
    finish_and_check("R4 R6 protected same stream");

    // R4 random IDs, stream mostly in narrow range
    do_clear();
    cfg_word = 12'h3E7; id_words = {16'($urandom), 16'($urandom), 16'($urandom)};
    for (int i = 0; i < 100; i++) send(11'($urandom_range(0, 'h7F)), 14'($urandom));
    finish_and_check("R4 protected narrow");

    // R7 only out-of-range addresses: result is config term alone
    do_clear();
    cfg_word = 12'hFFF;
    send(11'h3FF, 14'h0FFF); send(11'h7FF, 14'h0ABC); send(11'h440, 14'h0123);
    finish_and_check("R7 out of range");
    check("R7 config only", 32'(sum_out), 32'h3FF);
    cfg_word = 12'hFEF; id_words = '0;
    send(11'h040, 14'h0777); send(11'h3FE, 14'h0111);
    finish_and_check("R7 protected ignores mid range");
    check("R7 protected value", 32'(sum_out), 32'h3EF);

    // R8 upper data bits ignored
    do_clear();
    cfg_word = 12'h010;
    send(11'h001, 14'h3001);
    finish_and_check("R8 upper bits");
    check("R8 value", 32'(sum_out), 32'h011);

    // R2 wraparound with all-ones words
    do_clear();
    cfg_word = 12'hFFF;
    for (int i = 0; i < 40; i++) send(11'(i), 14'h3FFF);
    finish_and_check("R2 wrap");
    check("R2 wrap value", 32'(sum_out), 32'((40 * 32'hFFF + 32'h3FF) & 32'hFFFF));

    // R9 clear concurrent with a word drops the word
    do_clear();
    cfg_word = 12'hFFF;
    send(11'h010, 14'h0100);
    @(negedge clk); clr = 1'b1; word_vld = 1'b1; word_addr = 11'h011; word_data = 14'h0222;
    @(negedge clk); clr = 1'b0; word_vld = 1'b0;
    m_wide = '0; m_narrow = '0;
    finish_and_check("R9 clear wins");
    check("R9 value", 32'(sum_out), 32'h3FF);

    // R3 R4 mixed random rounds with random protection
    for (int r = 0; r < 6; r++) begin
      do_clear();
      cfg_word = 12'($urandom);
      id_words = {16'($urandom), 16'($urandom), 16'($urandom)};
      random_stream(200);
      finish_and_check(cfg_word[4] ? "R3 random round" : "R4 random round");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule